// File: doc/BRIEF.md
# Scan-Chain Debug Bridge

This block connects a host-side serial scan port to the debug controls of a processor core. The host picks one of four data registers with a two-bit selector. It then runs a capture, shift, update sequence. In that sequence a value is loaded into a shared shift register, exchanged serially one bit per shift-clock edge with the least significant bit first, and committed. The four registers are an identification word, a status/control word, a debug data word and a procedure launcher.

The core side works on its own clock. The bridge drives a halt request (seize), a core reset, a 16-bit write value with a one-cycle write enable, and an 8-bit procedure number with a one-cycle run pulse. It samples the core's stopped flag and a 16-bit result value that the core posts with a strobe. Committed writes reach the core clock as toggle-synchronized events. Level controls and flags cross through flop synchronizers.

To halt the core, the host clears the run bit and polls until the bit reads 0. It then loads data, launches procedures and reads back results. To resume, it sets the run bit and launches procedure 0.

Top module: `dbg_bridge`

## Requirements
- R1: With selector 00 the 32-bit identification value (parameter `ID_VALUE`) is shifted out, and any bits shifted in leave it unchanged.
- R2: Each selector value gives its own register length: 00 is 32 bits, 01 and 10 are 17 bits, and 11 is 8 bits. Bit 16 of the 17-bit registers is the flag bit.
- R3: Status read (selector 01): bit 0 reads 1 while `coreStopped` is low and 0 while it is high. Bit 1 reads the current reset setting. All other bits read 0.
- R4: A status write takes effect only when shifted-in bit 16 is 1. In that case bit 0 = 0 asserts `dbgSeize`, bit 0 = 1 releases it, and bit 1 sets `coreReset`. When bit 16 is 0 nothing changes.
- R5: A debug-data write (selector 10) with bit 16 = 1 gives exactly one core-clock cycle of `wrEn`, with `wrVal` equal to shifted-in bits 15:0. With bit 16 = 0 there is no pulse and `wrVal` keeps its value.
- R6: A debug-data read returns the last value posted by `coreValStb` in bits 15:0 and a valid flag in bit 16. The flag is set by the strobe and cleared when a procedure is dispatched.
- R7: A procedure write (selector 11) while `coreStopped` is high gives exactly one core-clock cycle of `procRun`, with `procAddr` equal to the 8 shifted-in bits. `procAddr` changes only with that pulse.
- R8: A procedure write while `coreStopped` is low is dropped: there is no pulse and `procAddr` keeps its value.
- R9: After reset `dbgSeize`, `coreReset`, `procRun` and `wrEn` are low, and `procAddr` and `wrVal` are 0.
- R10: Serial data moves least significant bit first. `tdo` shows bit 0 of the shift register, and `tdi` enters at the top bit of the selected register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Shift clock |
| tckRstN | input | 1 | Active-low asynchronous reset, shift domain |
| irSel | input | 2 | Data register selector, sampled at capture |
| captureDr | input | 1 | Capture strobe |
| shiftDr | input | 1 | Shift enable |
| updateDr | input | 1 | Update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| clk | input | 1 | Core clock |
| coreRstN | input | 1 | Active-low asynchronous reset, core domain |
| coreStopped | input | 1 | Core reports debug halt |
| coreResult | input | 16 | Result value from the core |
| coreValStb | input | 1 | Result strobe |
| dbgSeize | output | 1 | Halt request to the core |
| coreReset | output | 1 | Reset request to the core |
| procAddr | output | 8 | Procedure number |
| procRun | output | 1 | One-cycle procedure launch |
| wrVal | output | 16 | Value to load into the core |
| wrEn | output | 1 | One-cycle write enable for `wrVal` |

## Verification
The hardest case to reach is a launch that arrives while the core is still running. From the ports it looks just like a successful launch that never produced a pulse. The stimulus therefore first sweeps every procedure number with the core stopped and counts exactly one pulse per write. Only then does it lower `coreStopped` and repeat a write, so that a missing pulse and an unchanged `procAddr` are clear evidence that the gate works. The clearing of the valid flag at dispatch is also reached only through the scan port: a result is posted, read back as valid, a procedure is launched, and the register is read again.

// File: rtl/dbg_bridge_pkg.sv
package dbg_bridge_pkg;

  typedef enum logic [1:0] {
    SEL_IDENT  = 2'b00,
    SEL_STATUS = 2'b01,
    SEL_VALUE  = 2'b10,
    SEL_PROC   = 2'b11
  } drSel_e;

  // strobes from the scan control to the datapath
  typedef struct packed {
    logic   capture;
    logic   shift;
    logic   update;
    drSel_e sel;
  } drStrobe_t;

endpackage

// File: rtl/dbg_bridge_sync.sv
module dbg_bridge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[g] <= 1'b0;
        else       chain[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[g] <= 1'b0;
        else       chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dbg_bridge_ctrl.sv
module dbg_bridge_ctrl
  import dbg_bridge_pkg::*;
(
  input  logic      tck,
  input  logic      tckRstN,
  input  logic [1:0] irSel,
  input  logic      captureDr,
  input  logic      shiftDr,
  input  logic      updateDr,
  output drStrobe_t strb
);
  drSel_e selQ;

  // selector is frozen at capture so a scan cannot change register mid-way
  always_ff @(posedge tck or negedge tckRstN) begin
    if (!tckRstN)       selQ <= SEL_IDENT;
    else if (captureDr) selQ <= drSel_e'(irSel);
  end

  always_comb begin
    strb.capture = captureDr;
    strb.shift   = shiftDr & ~captureDr;
    strb.update  = updateDr & ~captureDr & ~shiftDr;
    strb.sel     = captureDr ? drSel_e'(irSel) : selQ;
  end
endmodule

// File: rtl/dbg_bridge_dp.sv
module dbg_bridge_dp
  import dbg_bridge_pkg::*;
#(
  parameter int                ID_W     = 32,
  parameter logic [ID_W-1:0]   ID_VALUE = 32'h0F0F_5A17,
  parameter int                DATA_W   = 16,
  parameter int                PROC_W   = 8,
  parameter int                SYNC_N   = 2
) (
  input  logic              tck,
  input  logic              tckRstN,
  input  drStrobe_t         strb,
  input  logic              tdi,
  output logic              tdo,
  input  logic              clk,
  input  logic              coreRstN,
  input  logic              coreStopped,
  input  logic [DATA_W-1:0] coreResult,
  input  logic              coreValStb,
  output logic              dbgSeize,
  output logic              coreReset,
  output logic [PROC_W-1:0] procAddr,
  output logic              procRun,
  output logic [DATA_W-1:0] wrVal,
  output logic              wrEn
);
  localparam int FLAG   = DATA_W;
  localparam int STAT_W = DATA_W + 1;
  localparam int SR_W   = (ID_W > STAT_W) ? ID_W : STAT_W;
  localparam int IDX_W  = $clog2(SR_W);

  // ---------------- shift-clock domain ----------------
  logic [SR_W-1:0]   sr, srCap, srNext;
  logic [IDX_W-1:0]  topIdx;
  logic              seizeQ, resetQ, wrTgl, runTgl;
  logic [DATA_W-1:0] wrValQ;
  logic [PROC_W-1:0] procQ;
  logic              stoppedSync, validSync;
  logic [DATA_W-1:0] resultQ;
  logic              validQ;

  always_comb begin
    case (strb.sel)
      SEL_IDENT:  topIdx = IDX_W'(ID_W - 1);
      SEL_PROC:   topIdx = IDX_W'(PROC_W - 1);
      default:    topIdx = IDX_W'(FLAG);
    endcase
  end

  always_comb begin
    srCap = '0;
    case (strb.sel)
      SEL_IDENT:  srCap[ID_W-1:0] = ID_VALUE;
      SEL_STATUS: begin
        srCap[0] = ~stoppedSync;
        srCap[1] = resetQ;
      end
      SEL_VALUE:  begin
        srCap[DATA_W-1:0] = resultQ;
        srCap[FLAG]       = validSync;
      end
      default:    srCap = '0;
    endcase
  end

  always_comb begin
    srNext         = sr >> 1;
    srNext[topIdx] = tdi;
  end

  assign tdo = sr[0];

  always_ff @(posedge tck or negedge tckRstN) begin
    if (!tckRstN) begin
      sr     <= '0;
      seizeQ <= 1'b0;
      resetQ <= 1'b0;
      wrValQ <= '0;
      wrTgl  <= 1'b0;
      procQ  <= '0;
      runTgl <= 1'b0;
    end else if (strb.capture) begin
      sr <= srCap;
    end else if (strb.shift) begin
      sr <= srNext;
    end else if (strb.update) begin
      case (strb.sel)
        SEL_STATUS: if (sr[FLAG]) begin
          seizeQ <= ~sr[0];
          resetQ <= sr[1];
        end
        SEL_VALUE: if (sr[FLAG]) begin
          wrValQ <= sr[DATA_W-1:0];
          wrTgl  <= ~wrTgl;
        end
        SEL_PROC: begin
          procQ  <= sr[PROC_W-1:0];
          runTgl <= ~runTgl;
        end
        default: ;
      endcase
    end
  end

  dbg_bridge_sync #(.STAGES(SYNC_N)) u_syncStop (
    .clk(tck), .rstN(tckRstN), .d(coreStopped), .q(stoppedSync));
  dbg_bridge_sync #(.STAGES(SYNC_N)) u_syncValid (
    .clk(tck), .rstN(tckRstN), .d(validQ), .q(validSync));

  // ---------------- core-clock domain ----------------
  logic wrTglS, wrTglD, runTglS, runTglD;
  logic wrPulse, runPulse, dispatch;

  dbg_bridge_sync #(.STAGES(SYNC_N)) u_syncSeize (
    .clk(clk), .rstN(coreRstN), .d(seizeQ), .q(dbgSeize));
  dbg_bridge_sync #(.STAGES(SYNC_N)) u_syncReset (
    .clk(clk), .rstN(coreRstN), .d(resetQ), .q(coreReset));
  dbg_bridge_sync #(.STAGES(SYNC_N)) u_syncWr (
    .clk(clk), .rstN(coreRstN), .d(wrTgl), .q(wrTglS));
  dbg_bridge_sync #(.STAGES(SYNC_N)) u_syncRun (
    .clk(clk), .rstN(coreRstN), .d(runTgl), .q(runTglS));

  assign wrPulse  = wrTglS ^ wrTglD;
  assign runPulse = runTglS ^ runTglD;
  assign dispatch = runPulse & coreStopped;

  always_ff @(posedge clk or negedge coreRstN) begin
    if (!coreRstN) begin
      wrTglD   <= 1'b0;
      runTglD  <= 1'b0;
      wrEn     <= 1'b0;
      wrVal    <= '0;
      procRun  <= 1'b0;
      procAddr <= '0;
      resultQ  <= '0;
      validQ   <= 1'b0;
    end else begin
      wrTglD  <= wrTglS;
      runTglD <= runTglS;
      wrEn    <= wrPulse;
      if (wrPulse) wrVal <= wrValQ;
      procRun <= dispatch;
      if (dispatch) procAddr <= procQ;
      if (coreValStb) begin
        resultQ <= coreResult;
        validQ  <= 1'b1;
      end else if (dispatch) begin
        validQ  <= 1'b0;
      end
    end
  end

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!coreRstN)
    wrEn |=> !wrEn);                                       // R5
  AST_RUN_SINGLE: assert property (@(posedge clk) disable iff (!coreRstN)
    procRun |=> !procRun);                                 // R7
  AST_PROC_HELD: assert property (@(posedge clk) disable iff (!coreRstN)
    !procRun |-> $stable(procAddr));                       // R7
  AST_RUN_GATED: assert property (@(posedge clk) disable iff (!coreRstN)
    procRun |-> $past(coreStopped));                       // R8
  AST_VALID_CLEAR: assert property (@(posedge clk) disable iff (!coreRstN)
    (procRun && !$past(coreValStb)) |-> !validQ);          // R6
endmodule

// File: rtl/dbg_bridge.sv
module dbg_bridge
  import dbg_bridge_pkg::*;
#(
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h0F0F_5A17,
  parameter int              DATA_W   = 16,
  parameter int              PROC_W   = 8,
  parameter int              SYNC_N   = 2
) (
  input  logic              tck,
  input  logic              tckRstN,
  input  logic [1:0]        irSel,
  input  logic              captureDr,
  input  logic              shiftDr,
  input  logic              updateDr,
  input  logic              tdi,
  output logic              tdo,
  input  logic              clk,
  input  logic              coreRstN,
  input  logic              coreStopped,
  input  logic [DATA_W-1:0] coreResult,
  input  logic              coreValStb,
  output logic              dbgSeize,
  output logic              coreReset,
  output logic [PROC_W-1:0] procAddr,
  output logic              procRun,
  output logic [DATA_W-1:0] wrVal,
  output logic              wrEn
);
  drStrobe_t strb;

  dbg_bridge_ctrl u_ctrl (
    .tck(tck), .tckRstN(tckRstN), .irSel(irSel),
    .captureDr(captureDr), .shiftDr(shiftDr), .updateDr(updateDr),
    .strb(strb));

  dbg_bridge_dp #(
    .ID_W(ID_W), .ID_VALUE(ID_VALUE), .DATA_W(DATA_W),
    .PROC_W(PROC_W), .SYNC_N(SYNC_N)
  ) u_dp (
    .tck(tck), .tckRstN(tckRstN), .strb(strb), .tdi(tdi), .tdo(tdo),
    .clk(clk), .coreRstN(coreRstN), .coreStopped(coreStopped),
    .coreResult(coreResult), .coreValStb(coreValStb),
    .dbgSeize(dbgSeize), .coreReset(coreReset), .procAddr(procAddr),
    .procRun(procRun), .wrVal(wrVal), .wrEn(wrEn));
endmodule

// File: tb/dbg_bridge_tb.sv
`timescale 1ns/1ps
module dbg_bridge_tb;
  localparam logic [31:0] ID = 32'h1BAD_C0DE;
  localparam logic [31:0] WE = 32'h0001_0000;

  logic tck = 0, clk = 0, tckRstN = 0, coreRstN = 0;
  logic [1:0] irSel = 0;
  logic captureDr = 0, shiftDr = 0, updateDr = 0, tdi = 0;
  logic coreStopped = 0, coreValStb = 0;
  logic [15:0] coreResult = 0;
  logic tdo, dbgSeize, coreReset, procRun, wrEn;
  logic [7:0] procAddr;
  logic [15:0] wrVal;

  int checks = 0, failures = 0;
  int runCnt = 0, wrCnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always #13  tck = ~tck;

  dbg_bridge #(.ID_VALUE(ID)) u_dut (
    .tck(tck), .tckRstN(tckRstN), .irSel(irSel), .captureDr(captureDr),
    .shiftDr(shiftDr), .updateDr(updateDr), .tdi(tdi), .tdo(tdo),
    .clk(clk), .coreRstN(coreRstN), .coreStopped(coreStopped),
    .coreResult(coreResult), .coreValStb(coreValStb),
    .dbgSeize(dbgSeize), .coreReset(coreReset), .procAddr(procAddr),
    .procRun(procRun), .wrVal(wrVal), .wrEn(wrEn));

  always @(negedge clk) begin
    if (procRun) runCnt++;
    if (wrEn)    wrCnt++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic scan(input logic [1:0] ir, input logic [31:0] din,
                      input int len, output logic [31:0] dout);
    @(negedge tck); irSel = ir; captureDr = 1;
    @(negedge tck); captureDr = 0; shiftDr = 1; dout = '0;
    for (int i = 0; i < len; i++) begin
      dout[i] = tdo;
      tdi = din[i];
      @(negedge tck);
    end
    shiftDr = 0; updateDr = 1;
    @(negedge tck); updateDr = 0;
  endtask

  task automatic settle();
    repeat (4) @(negedge tck);
  endtask

  initial begin
    #750000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int r0, w0;
    logic [7:0] pa;
    logic [15:0] wv;
    logic [15:0] pats [0:17];

    repeat (5) @(negedge clk);
    tckRstN = 1; coreRstN = 1;
    repeat (3) @(negedge tck);

    // R9 reset state
    check(!dbgSeize && !coreReset && !procRun && !wrEn && procAddr == 0 && wrVal == 0,
          "R9", "reset outputs", {dbgSeize, coreReset, procRun, wrEn}, 0);

    // R1 R10 R2 identification, LSB first, write ignored
    scan(2'b00, 32'hFFFF_FFFF, 32, d);
    check(d == ID, "R1", "ident read (R10 lsb first, R2 32 bits)", d, ID);
    scan(2'b00, 32'h0, 32, d);
    check(d == ID, "R1", "ident after shift-in", d, ID);

    // R3 status while running
    scan(2'b01, 32'h0, 17, d);
    check(d[16:0] == 17'h1, "R3", "status running (R2 17 bits)", d[16:0], 1);

    // R4 halt request
    scan(2'b01, WE | 32'h0, 17, d);
    repeat (10) @(negedge clk);
    check(dbgSeize == 1, "R4", "seize asserted", dbgSeize, 1);
    coreStopped = 1; settle();
    scan(2'b01, 32'h0, 17, d);
    check(d[16:0] == 17'h0, "R3", "status stopped", d[16:0], 0);

    // R4 write without enable ignored
    scan(2'b01, 32'h3, 17, d);
    repeat (10) @(negedge clk);
    check(dbgSeize == 1 && coreReset == 0, "R4", "no-enable write ignored",
          {dbgSeize, coreReset}, 2'b10);

    // R4 reset control
    scan(2'b01, WE | 32'h2, 17, d);
    repeat (10) @(negedge clk);
    check(coreReset == 1 && dbgSeize == 1, "R4", "reset set", {dbgSeize, coreReset}, 2'b11);
    scan(2'b01, 32'h0, 17, d);
    check(d[16:0] == 17'h2, "R3", "status reset bit", d[16:0], 2);
    scan(2'b01, WE | 32'h0, 17, d);
    repeat (10) @(negedge clk);
    check(coreReset == 0, "R4", "reset cleared", coreReset, 0);

    // R5 debug value writes: walking ones plus two patterns
    for (int i = 0; i < 16; i++) pats[i] = 16'(1) << i;
    pats[16] = 16'hA5C3; pats[17] = 16'hFFFF;
    for (int i = 0; i < 18; i++) begin
      w0 = wrCnt;
      scan(2'b10, WE | 32'(pats[i]), 17, d);
      repeat (10) @(negedge clk);
      check(wrCnt - w0 == 1, "R5", "one wrEn cycle", wrCnt - w0, 1);
      check(wrVal == pats[i], "R5", "wrVal", wrVal, pats[i]);
    end
    w0 = wrCnt; wv = wrVal;
    scan(2'b10, 32'h1234, 17, d);
    repeat (10) @(negedge clk);
    check(wrCnt == w0 && wrVal == wv, "R5", "no-enable write dropped", wrVal, wv);

    // R6 result readback
    scan(2'b10, 32'h0, 17, d);
    check(d[16] == 0, "R6", "valid low before post", d[16:0], 0);
    @(negedge clk); coreResult = 16'h3C5A; coreValStb = 1;
    @(negedge clk); coreValStb = 0; coreResult = 16'h0;
    settle();
    scan(2'b10, 32'h0, 17, d);
    check(d[16:0] == 17'h13C5A, "R6", "valid result", d[16:0], 17'h13C5A);

    // R7 sweep all procedure numbers with core stopped
    for (int p = 0; p < 256; p++) begin
      r0 = runCnt;
      scan(2'b11, 32'(p), 8, d);
      repeat (10) @(negedge clk);
      check(runCnt - r0 == 1 && procAddr == 8'(p), "R7", "dispatch",
            {runCnt - r0, procAddr}, {32'd1, 8'(p)});
    end
    settle();
    scan(2'b10, 32'h0, 17, d);
    check(d[16] == 0 && d[15:0] == 16'h3C5A, "R6", "valid cleared by dispatch",
          d[16:0], 17'h03C5A);

    // R8 launch while running is dropped
    coreStopped = 0; pa = procAddr; r0 = runCnt;
    repeat (4) @(negedge clk);
    scan(2'b11, 32'h5A, 8, d);
    repeat (10) @(negedge clk);
    check(runCnt == r0 && procAddr == pa, "R8", "dropped launch",
          {runCnt - r0, procAddr}, {32'd0, pa});

    // R4 resume: release seize
    scan(2'b01, WE | 32'h1, 17, d);
    repeat (10) @(negedge clk);
    check(dbgSeize == 0, "R4", "seize released", dbgSeize, 0);
    settle();
    scan(2'b01, 32'h0, 17, d);
    check(d[16:0] == 17'h1, "R3", "status running again", d[16:0], 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule